// File: doc/BRIEF.md
# Compressed Sparse Matrix-Vector Processing Element

This block is one processing element of a sparse-matrix times sparse-vector engine. The matrix rows are spread across many such elements; each element keeps only its own rows, held column by column in compressed form. A shared broadcaster sends every nonzero input activation, with its column index, to all elements at once. Each element queues these pairs in a small local FIFO, so that an element with a heavy column does not stall the broadcast while a neighbour with a light column sits idle.

For each queued pair the element makes two reads of a local pointer memory. The first read, at the column's index, gives the column's first entry. The second read, at the next index, gives the end of the column. The element then steps through the stored entries of that column, one per cycle. Each entry is one byte. The byte carries a 4-bit codeword, which selects a signed 16-bit weight from a 16-slot codebook, and a 4-bit run of skipped rows. The decode stage rebuilds the local row number and looks up the weight. The last stage multiplies the weight by the activation and adds the product into that row's running sum.

A run of zeros longer than fifteen rows is stored as a filler entry that uses codeword 0, which always decodes to weight zero. The matrix memories and the codebook are loaded through plain write ports, and any row sum can be read combinationally. A flush input clears all sums before a new vector is processed.

Top module: `spmv_pe`

## Requirements
- R1: `act_ready` is high exactly when fewer than FIFO_DEPTH activations wait in the queue. A pair is taken only on a cycle with `act_valid` and `act_ready` both high, and the queue never holds more than FIFO_DEPTH pairs.
- R2: An activation for column c visits the entry addresses from ptr[c] up to ptr[c+1]-1, in ascending order and one per cycle. Pointer slot NCOL holds the end of the last column.
- R3: In an entry byte, bits 7:4 are the codeword and bits 3:0 are the increment. The first entry of a column lands on row = increment. Each later entry lands on row = previous row + increment + 1.
- R4: Codeword 0 always decodes to weight zero, and a write to codebook slot 0 has no effect. Codewords 1 to 15 decode to the last value written to their slot.
- R5: Each visited entry adds the signed product weight × activation to the sum of its row, with the sum wrapping at ACC_W bits. Sums keep accumulating across activations.
- R6: An entry whose row is NROW or greater changes no sum.
- R7: A flush pulse clears every row sum on the next cycle. If an update to a row falls on the same cycle as the flush, the flush wins.
- R8: After reset all row sums read zero, the queue is empty and `act_ready` is high.
- R9: An activation for a column whose start pointer equals its end pointer changes no sum.
- R10: Every accepted activation is processed exactly once, in the order it was accepted, including when pairs arrive back to back while the queue fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| act_valid | input | 1 | Broadcast pair present |
| act_value | input | ACT_W | Signed activation value |
| act_col | input | log2(NCOL) | Column index of the activation |
| act_ready | output | 1 | Queue can take a pair |
| flush | input | 1 | Clear all row sums |
| ptr_we | input | 1 | Pointer memory write enable |
| ptr_waddr | input | log2(NCOL)+1 | Pointer slot, 0 to NCOL |
| ptr_wdata | input | log2(NENT+1) | Entry address stored in the slot |
| ent_we | input | 1 | Entry memory write enable |
| ent_waddr | input | log2(NENT) | Entry address |
| ent_wdata | input | 8 | Codeword (7:4) and row increment (3:0) |
| cb_we | input | 1 | Codebook write enable |
| cb_waddr | input | 4 | Codebook slot |
| cb_wdata | input | WT_W | Signed weight value |
| rd_row | input | log2(NROW) | Local row to read |
| rd_sum | output | ACC_W | Sum of the selected row |

## Verification
The hardest situation to reach from the ports is a full queue with the walker still busy on a long column, because the broadcaster only ever sees `act_ready`. The bench sends ten activations back to back for a four-entry column, so each one takes about eight cycles to walk. It records that `act_ready` fell, then checks that every row total equals ten accumulated contributions. Row positions that run past the owned rows, filler entries with codeword 0, and empty columns are built into a dedicated column and into the sweep, and their absence of effect is checked by reading back every row sum.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
    localparam int CODE_W = 4;
    localparam int INC_W  = 4;
    localparam int ENT_W  = CODE_W + INC_W;
    localparam int CB_N   = 1 << CODE_W;

    typedef enum logic [1:0] {
        W_IDLE,
        W_START,
        W_END,
        W_WALK
    } walk_st_e;
endpackage

// File: rtl/spmv_act_fifo.sv
module spmv_act_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [W-1:0]               in_data,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic [W-1:0]               out_data,
    input  logic                       out_pop,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push, pop;

    always_comb begin
        s_d      = s_q;
        in_ready = (s_q.cnt != (AW+1)'(DEPTH));
        push     = in_valid && in_ready;
        pop      = out_pop && (s_q.cnt != '0);
        if (push) s_d.wr = s_q.wr + 1'b1;
        if (pop)  s_d.rd = s_q.rd + 1'b1;
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wr] <= in_data;
    end

    assign out_valid = (s_q.cnt != '0);
    assign out_data  = mem_q[s_q.rd];
    assign count     = s_q.cnt;
endmodule

// File: rtl/spmv_col_walker.sv
module spmv_col_walker
    import spmv_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int PTR_W = 7,
    parameter int ACT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_valid,
    input  logic [COL_W-1:0] q_col,
    input  logic [ACT_W-1:0] q_act,
    output logic             q_pop,
    output logic [COL_W:0]   ptr_raddr,
    input  logic [PTR_W-1:0] ptr_rdata,
    output logic             iss_valid,
    output logic [PTR_W-1:0] iss_addr,
    output logic             iss_first,
    output logic [ACT_W-1:0] iss_act,
    output logic [PTR_W-1:0] walk_stop
);
    typedef struct packed {
        walk_st_e         st;
        logic [COL_W-1:0] col;
        logic [ACT_W-1:0] act;
        logic [PTR_W-1:0] start;
        logic [PTR_W-1:0] stop;
        logic [PTR_W-1:0] cur;
        logic             first;
    } walk_t;

    walk_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        q_pop     = 1'b0;
        iss_valid = 1'b0;
        ptr_raddr = {1'b0, s_q.col};
        case (s_q.st)
            W_IDLE: begin
                if (q_valid) begin
                    q_pop   = 1'b1;
                    s_d.col = q_col;
                    s_d.act = q_act;
                    s_d.st  = W_START;
                end
            end
            W_START: begin
                s_d.start = ptr_rdata;
                s_d.st    = W_END;
            end
            W_END: begin
                ptr_raddr = {1'b0, s_q.col} + 1'b1;
                s_d.stop  = ptr_rdata;
                s_d.cur   = s_q.start;
                s_d.first = 1'b1;
                s_d.st    = W_WALK;
            end
            default: begin
                if (s_q.cur < s_q.stop) begin
                    iss_valid = 1'b1;
                    s_d.cur   = s_q.cur + 1'b1;
                    s_d.first = 1'b0;
                end else begin
                    s_d.st = W_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: W_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign iss_addr  = s_q.cur;
    assign iss_first = s_q.first;
    assign iss_act   = s_q.act;
    assign walk_stop = s_q.stop;
endmodule

// File: rtl/spmv_pe.sv
module spmv_pe
    import spmv_pkg::*;
#(
    parameter int NCOL       = 16,
    parameter int NROW       = 32,
    parameter int NENT       = 64,
    parameter int FIFO_DEPTH = 4,
    parameter int ACT_W      = 16,
    parameter int WT_W       = 16,
    parameter int ACC_W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      act_valid,
    input  logic [ACT_W-1:0]          act_value,
    input  logic [$clog2(NCOL)-1:0]   act_col,
    output logic                      act_ready,
    input  logic                      flush,
    input  logic                      ptr_we,
    input  logic [$clog2(NCOL):0]     ptr_waddr,
    input  logic [$clog2(NENT+1)-1:0] ptr_wdata,
    input  logic                      ent_we,
    input  logic [$clog2(NENT)-1:0]   ent_waddr,
    input  logic [ENT_W-1:0]          ent_wdata,
    input  logic                      cb_we,
    input  logic [CODE_W-1:0]         cb_waddr,
    input  logic [WT_W-1:0]           cb_wdata,
    input  logic [$clog2(NROW)-1:0]   rd_row,
    output logic [ACC_W-1:0]          rd_sum
);
    localparam int COL_W  = $clog2(NCOL);
    localparam int PTR_W  = $clog2(NENT+1);
    localparam int ENT_AW = $clog2(NENT);
    localparam int ROW_W  = $clog2(NROW);
    localparam int RPOS_W = ROW_W + 1;
    localparam int SUM_W  = RPOS_W + INC_W + 1;
    localparam int PRD_W  = WT_W + ACT_W;
    localparam int QW     = COL_W + ACT_W;

    // local matrix memories
    logic [PTR_W-1:0] ptr_mem [NCOL+1];
    logic [ENT_W-1:0] ent_mem [NENT];
    logic [WT_W-1:0]  cb_mem  [CB_N];

    always_ff @(posedge clk) begin
        if (ptr_we && (ptr_waddr <= (COL_W+1)'(NCOL))) ptr_mem[ptr_waddr] <= ptr_wdata;
        if (ent_we) ent_mem[ent_waddr] <= ent_wdata;
        if (cb_we && (cb_waddr != '0)) cb_mem[cb_waddr] <= cb_wdata;
    end

    // activation queue
    logic                   q_valid, q_pop;
    logic [QW-1:0]          q_data;
    logic [$clog2(FIFO_DEPTH):0] fifo_cnt;

    spmv_act_fifo #(.DEPTH(FIFO_DEPTH), .W(QW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(act_valid), .in_data({act_col, act_value}), .in_ready(act_ready),
        .out_valid(q_valid), .out_data(q_data), .out_pop(q_pop),
        .count(fifo_cnt)
    );

    // pointer read and column walk
    logic [COL_W:0]   ptr_raddr;
    logic             iss_valid, iss_first;
    logic [PTR_W-1:0] iss_addr, walk_stop;
    logic [ACT_W-1:0] iss_act;

    spmv_col_walker #(.COL_W(COL_W), .PTR_W(PTR_W), .ACT_W(ACT_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_col(q_data[QW-1:ACT_W]), .q_act(q_data[ACT_W-1:0]), .q_pop(q_pop),
        .ptr_raddr(ptr_raddr), .ptr_rdata(ptr_mem[ptr_raddr]),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_first(iss_first), .iss_act(iss_act),
        .walk_stop(walk_stop)
    );

    // entry read, decode, multiply-accumulate
    typedef struct packed {
        logic              e_v;
        logic              e_first;
        logic [ACT_W-1:0]  e_act;
        logic [ENT_W-1:0]  e_ent;
        logic              d_v;
        logic [RPOS_W-1:0] d_row;
        logic [WT_W-1:0]   d_wt;
        logic [ACT_W-1:0]  d_act;
        logic [RPOS_W-1:0] rpos;
    } pipe_t;

    pipe_t p_d, p_q;
    logic [ACC_W-1:0] acc_d [NROW];
    logic [ACC_W-1:0] acc_q [NROW];

    logic [CODE_W-1:0] code;
    logic [INC_W-1:0]  inc;
    logic [SUM_W-1:0]  base, nxt;
    logic [RPOS_W-1:0] row_c;
    logic signed [PRD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;

    always_comb begin
        p_d         = p_q;
        p_d.e_v     = iss_valid;
        p_d.e_first = iss_first;
        p_d.e_act   = iss_act;
        p_d.e_ent   = ent_mem[iss_addr[ENT_AW-1:0]];

        code  = p_q.e_ent[ENT_W-1:INC_W];
        inc   = p_q.e_ent[INC_W-1:0];
        base  = p_q.e_first ? '0 : SUM_W'(p_q.rpos) + 1'b1;
        nxt   = base + SUM_W'(inc);
        // saturate once past the owned rows so the position never wraps back
        row_c = (nxt >= SUM_W'(NROW)) ? RPOS_W'(NROW) : nxt[RPOS_W-1:0];

        p_d.d_v   = p_q.e_v;
        p_d.d_row = row_c;
        p_d.d_wt  = (code == '0) ? '0 : cb_mem[code];
        p_d.d_act = p_q.e_act;
        if (p_q.e_v) p_d.rpos = row_c;

        prod     = $signed(p_q.d_wt) * $signed(p_q.d_act);
        prod_ext = ACC_W'(prod);
        for (int r = 0; r < NROW; r++) begin
            acc_d[r] = acc_q[r];
            if (flush)
                acc_d[r] = '0;
            else if (p_q.d_v && (p_q.d_row == RPOS_W'(r)))
                acc_d[r] = acc_q[r] + prod_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            for (int r = 0; r < NROW; r++) acc_q[r] <= '0;
        end else begin
            p_q <= p_d;
            for (int r = 0; r < NROW; r++) acc_q[r] <= acc_d[r];
        end
    end

    assign rd_sum = acc_q[rd_row];
endmodule

// File: rtl/spmv_pe_chk.sv
module spmv_pe_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CW         = 3,
    parameter int PTR_W      = 7,
    parameter int ROW_W      = 5,
    parameter int ACC_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_valid,
    input logic             act_ready,
    input logic             flush,
    input logic [ROW_W-1:0] rd_row,
    input logic [ACC_W-1:0] rd_sum,
    input logic [CW-1:0]    fifo_cnt,
    input logic             iss_valid,
    input logic             iss_first,
    input logic [PTR_W-1:0] iss_addr,
    input logic [PTR_W-1:0] walk_stop
);
    // R1: queue occupancy bounded
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(FIFO_DEPTH));

    // R1: refused pair does not grow the queue
    p_stall_no_growth_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !act_ready) |=> (fifo_cnt <= $past(fifo_cnt)));

    // R2: issued entry stays inside the column
    p_issue_below_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_addr < walk_stop));

    // R2: entries of a column are visited consecutively
    p_issue_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_first) |-> ($past(iss_valid) && (iss_addr == $past(iss_addr) + 1'b1)));

    // R7: flush clears the observed sum
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 $stable(rd_row)) |-> (rd_sum == '0));

    // R8: queue open right after reset
    p_ready_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> act_ready);
endmodule

bind spmv_pe spmv_pe_chk #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .CW($clog2(FIFO_DEPTH)+1),
    .PTR_W($clog2(NENT+1)),
    .ROW_W($clog2(NROW)),
    .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .act_valid(act_valid), .act_ready(act_ready), .flush(flush),
    .rd_row(rd_row), .rd_sum(rd_sum), .fifo_cnt(fifo_cnt),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_addr(iss_addr),
    .walk_stop(walk_stop)
);

// File: tb/spmv_pe_tb.sv
module spmv_pe_tb;
    localparam int NCOL = 16, NROW = 32, NENT = 64, DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [15:0] act_value = '0;
    logic [3:0]  act_col = '0;
    logic        act_ready;
    logic        flush = 1'b0;
    logic        ptr_we = 1'b0;
    logic [4:0]  ptr_waddr = '0;
    logic [6:0]  ptr_wdata = '0;
    logic        ent_we = 1'b0;
    logic [5:0]  ent_waddr = '0;
    logic [7:0]  ent_wdata = '0;
    logic        cb_we = 1'b0;
    logic [3:0]  cb_waddr = '0;
    logic [15:0] cb_wdata = '0;
    logic [4:0]  rd_row = '0;
    logic [31:0] rd_sum;

    spmv_pe #(.NCOL(NCOL), .NROW(NROW), .NENT(NENT), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_value(act_value), .act_col(act_col), .act_ready(act_ready),
        .flush(flush),
        .ptr_we(ptr_we), .ptr_waddr(ptr_waddr), .ptr_wdata(ptr_wdata),
        .ent_we(ent_we), .ent_waddr(ent_waddr), .ent_wdata(ent_wdata),
        .cb_we(cb_we), .cb_waddr(cb_waddr), .cb_wdata(cb_wdata),
        .rd_row(rd_row), .rd_sum(rd_sum)
    );

    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit low_seen = 0;

    int m_ptr [NCOL+1];
    int m_ent [NENT];
    int m_cb  [16];
    int exp_s [NROW];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int wt_of(input int code);
        return (code == 0) ? 0 : m_cb[code];
    endfunction

    // expected sums per requirements R2, R3, R4, R5, R6
    task automatic model_apply(input int col, input int val);
        int row = 0;
        for (int k = m_ptr[col]; k < m_ptr[col+1]; k++) begin
            int inc  = m_ent[k] & 15;
            int code = (m_ent[k] >> 4) & 15;
            row = (k == m_ptr[col]) ? inc : row + inc + 1;
            if (row < NROW) exp_s[row] += wt_of(code) * val;
        end
    endtask

    task automatic push(input int col, input int val);
        act_valid = 1'b1;
        act_col   = 4'(col);
        act_value = 16'(val);
        model_apply(col, val);
        while (!act_ready) begin
            low_seen = 1;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_rows(input string req);
        for (int r = 0; r < NROW; r++) begin
            rd_row = 5'(r);
            #1;
            chk($signed(rd_sum) == exp_s[r], req, $signed(rd_sum), exp_s[r]);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int pos;
        for (int r = 0; r < NROW; r++) exp_s[r] = 0;
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        chk(act_ready == 1'b1, "R8 ready", int'(act_ready), 1);
        check_rows("R8 sums");

        // codebook; slot 0 write must be ignored (R4)
        for (int k = 0; k < 16; k++) begin
            m_cb[k]  = (k == 0) ? 0 : k * 1234 - 9000;
            cb_we    = 1'b1;
            cb_waddr = 4'(k);
            cb_wdata = (k == 0) ? 16'h7777 : 16'(m_cb[k]);
            @(negedge clk);
        end
        cb_we = 1'b0;

        // matrix: columns 0..14 hold c%5 entries, column 15 holds fillers and out-of-range rows
        pos = 0;
        for (int c = 0; c < NCOL; c++) begin
            m_ptr[c] = pos;
            if (c < 15) begin
                for (int k = 0; k < c % 5; k++) begin
                    m_ent[pos] = (((c + 2*k + 1) % 16) << 4) | ((c*7 + k*5) % 16);
                    pos++;
                end
            end else begin
                m_ent[pos] = 8'h0F; m_ent[pos+1] = 8'h0F;   // rows 15, 31 with weight 0
                m_ent[pos+2] = 8'h5F; m_ent[pos+3] = 8'h30; // rows 47, 48 beyond NROW
                pos += 4;
            end
        end
        m_ptr[NCOL] = pos;
        for (int c = 0; c <= NCOL; c++) begin
            ptr_we = 1'b1; ptr_waddr = 5'(c); ptr_wdata = 7'(m_ptr[c]);
            @(negedge clk);
        end
        ptr_we = 1'b0;
        for (int e = 0; e < pos; e++) begin
            ent_we = 1'b1; ent_waddr = 6'(e); ent_wdata = 8'(m_ent[e]);
            @(negedge clk);
        end
        ent_we = 1'b0;

        // R2 R3 R5 R6 R10: one activation per column, including -32768
        for (int c = 0; c < 15; c++)
            push(c, (c == 3) ? -32768 : ((c * 2011) % 32768) - 16384);
        act_valid = 1'b0;
        wait_cycles(300);
        check_rows("R5 sweep");

        // R9: empty column changes nothing
        push(0, 12345);
        act_valid = 1'b0;
        wait_cycles(30);
        check_rows("R9 empty column");

        // R4 R6: fillers with codeword 0 and rows past NROW change nothing
        push(15, 30000);
        act_valid = 1'b0;
        wait_cycles(30);
        check_rows("R4 R6 filler and range");

        // R1 R10: back-to-back pairs on a four-entry column fill the queue
        low_seen = 0;
        for (int i = 0; i < 10; i++) push(4, -3 - 977 * i);
        act_valid = 1'b0;
        chk(low_seen == 1, "R1 ready drop", int'(low_seen), 1);
        wait_cycles(300);
        chk(act_ready == 1'b1, "R1 ready after drain", int'(act_ready), 1);
        check_rows("R10 back to back");

        // R7: flush clears everything, accumulation restarts from zero
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int r = 0; r < NROW; r++) exp_s[r] = 0;
        check_rows("R7 flush");
        push(2, 777);
        push(9, -1500);
        act_valid = 1'b0;
        wait_cycles(60);
        check_rows("R5 after flush");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule